// File: doc/BRIEF.md
# Transmit Overhead Insertion Port

This block sits on the bit-serial path of a transmit framer. It gives outside equipment control over single overhead bits. The frame is a sequence of blocks. Each block holds one overhead bit followed by a run of payload bits. The block counts positions in the frame and merges three sources into one serial output: internal overhead values, payload bits from the framer, and bits that outside equipment supplies.

In overhead mode, a shared marker pin pulses at the start of each frame. A separate enable output warns one clock before each overhead position. If the equipment raises its insert request on the edge that follows that warning, its data bit replaces the internal value.

In byte mode, the marker pin becomes a demand clock at one eighth of the bit rate. On each rising edge of the demand clock, a byte is taken from a parallel bus and sent out on the serial line, highest bit first. The active mode changes only where one frame ends and the next begins.

Top module: `ovh_insert_port`

## Requirements
- R1: A synchronous active-high reset drives `ser_o`, `mark_o` and `ovh_en_o` low. It sets the position counter to frame position 0 and loads the active mode from `mode_req_i`.
- R2: A frame has `BLOCKS` blocks of `1 + PAYLOAD_BITS` positions, and the overhead bit comes first in each block. In overhead mode (`mode_req_i` = 0), `mark_o` is high for exactly one cycle per frame: the cycle in which `ser_o` carries the overhead bit of position 0.
- R3: In overhead mode, `ovh_en_o` is high for exactly one cycle: the cycle just before the edge that processes an overhead position. That edge drives the overhead bit onto `ser_o` for the following cycle.
- R4: If `ins_req_i` is high on the edge that follows a cycle with `ovh_en_o` high, then `ser_o` shows the value of `ovh_dat_i` taken at that edge during the next cycle.
- R5: Otherwise, the overhead bit of block b is `cfg_ovh_i[b]`, with block 0 first in the frame. This includes the first overhead bit after reset, which has no preceding enable, so any insert request on that edge is ignored.
- R6: In overhead mode, each payload position sends out the value of `pay_bit_i` taken at the edge that processes it, one clock later on `ser_o`.
- R7: In byte mode (`mode_req_i` = 1), `mark_o` is a demand clock with a period of `BYTE_W` cycles. It is high for the first half and rises at the start of each frame. `ovh_en_o` stays low.
- R8: In byte mode, `byte_i` is taken only on the edge at which `mark_o` rises. Its value at all other edges has no effect on `ser_o`.
- R9: A byte taken from `byte_i` appears on `ser_o` over the `BYTE_W` cycles that start with the high phase of `mark_o`, bit `BYTE_W-1` first.
- R10: In byte mode, `ins_req_i`, `ovh_dat_i`, `pay_bit_i` and `cfg_ovh_i` have no effect on `ser_o`.
- R11: `mode_req_i` is sampled only on the edge that processes the last position of a frame. The new mode governs the whole next frame, including the enable ahead of its first overhead bit. Changes at any other time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 1 | Requested mode: 0 overhead, 1 byte |
| cfg_ovh_i | input | BLOCKS | Internal overhead value, one bit per block |
| pay_bit_i | input | 1 | Payload bit from the framer |
| ins_req_i | input | 1 | External insert request for the announced overhead bit |
| ovh_dat_i | input | 1 | External overhead value |
| byte_i | input | BYTE_W | Parallel data in byte mode |
| mark_o | output | 1 | Frame marker (overhead mode) or demand clock (byte mode) |
| ovh_en_o | output | 1 | One-cycle warning ahead of each overhead position |
| ser_o | output | 1 | Serial transmit output |

## Verification
The bench has a behavioural reference model that it compares on every clock. The model includes an insert request on the first overhead bit after reset. A design that honoured that request would send the external value where R5 requires the internal one.

The mode request moves in the middle of frames and also glitches briefly. An implementation that switched early would cut a byte in half, or would drop or duplicate an overhead enable at the boundary. The model detects both.

The byte bus and the insert inputs change on every cycle in byte mode. A design that sampled off the demand-clock rising edge, or that let insertion leak into byte mode, would corrupt the serial stream. Resets land both mid-frame and in byte mode, so a design that left stale state behind a reset would show up in the first frame after it.

// File: rtl/ovh_insert_pkg.sv
`timescale 1ns/1ps
package ovh_insert_pkg;
   typedef enum logic {
      MODE_OVH  = 1'b0,
      MODE_BYTE = 1'b1
   } port_mode_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ovh_frame_ctr.sv
`timescale 1ns/1ps
module ovh_frame_ctr
   import ovh_insert_pkg::*;
#(
   parameter int PAYLOAD_BITS = 84,
   parameter int BLOCKS       = 56,
   parameter int BYTE_W       = 8,
   localparam int BIT_W       = cnt_width(PAYLOAD_BITS + 1),
   localparam int BLK_W       = cnt_width(BLOCKS),
   localparam int PH_W        = cnt_width(BYTE_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_req_i,
   output logic             oh_now,
   output logic             oh_next,
   output logic             first_now,
   output logic [BLK_W-1:0] blk_idx,
   output logic [PH_W-1:0]  ph_idx,
   output port_mode_e       act_mode,
   output port_mode_e       nxt_mode
);
   logic [BIT_W-1:0] bit_q;
   logic [BLK_W-1:0] blk_q;
   logic [PH_W-1:0]  ph_q;
   port_mode_e       mode_q;

   logic bit_wrap, blk_wrap, ph_wrap, frame_last;

   assign bit_wrap   = (bit_q == BIT_W'(PAYLOAD_BITS));
   assign blk_wrap   = (blk_q == BLK_W'(BLOCKS - 1));
   assign ph_wrap    = (ph_q  == PH_W'(BYTE_W - 1));
   assign frame_last = bit_wrap && blk_wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_q  <= '0;
         blk_q  <= '0;
         ph_q   <= '0;
         mode_q <= port_mode_e'(mode_req_i);
      end else begin
         bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
         if (bit_wrap)
            blk_q <= blk_wrap ? '0 : blk_q + 1'b1;
         ph_q <= ph_wrap ? '0 : ph_q + 1'b1;
         if (frame_last)
            mode_q <= port_mode_e'(mode_req_i);
      end
   end

   assign oh_now    = (bit_q == '0);
   assign oh_next   = bit_wrap;
   assign first_now = oh_now && (blk_q == '0);
   assign blk_idx   = blk_q;
   assign ph_idx    = ph_q;
   assign act_mode  = mode_q;
   assign nxt_mode  = frame_last ? port_mode_e'(mode_req_i) : mode_q;
endmodule

// File: rtl/ovh_bit_path.sv
`timescale 1ns/1ps
module ovh_bit_path
   import ovh_insert_pkg::*;
#(
   parameter int BLOCKS = 56,
   localparam int BLK_W = cnt_width(BLOCKS)
) (
   input  logic              clk,
   input  logic              rst,
   input  port_mode_e        act_mode,
   input  port_mode_e        nxt_mode,
   input  logic              oh_now,
   input  logic              oh_next,
   input  logic              first_now,
   input  logic [BLK_W-1:0]  blk_idx,
   input  logic [BLOCKS-1:0] cfg_ovh_i,
   input  logic              pay_bit_i,
   input  logic              ins_req_i,
   input  logic              ovh_dat_i,
   output logic              ser_o,
   output logic              frm_o,
   output logic              en_o
);
   logic en_q, frm_q, ser_q;
   logic is_active, take_ext, oh_bit;

   assign is_active = (act_mode == MODE_OVH);
   assign take_ext  = en_q && ins_req_i;
   assign oh_bit    = take_ext ? ovh_dat_i : cfg_ovh_i[blk_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q  <= 1'b0;
         frm_q <= 1'b0;
         ser_q <= 1'b0;
      end else begin
         en_q  <= (nxt_mode == MODE_OVH) && oh_next;
         frm_q <= is_active && first_now;
         ser_q <= is_active && (oh_now ? oh_bit : pay_bit_i);
      end
   end

   assign ser_o = ser_q;
   assign frm_o = frm_q;
   assign en_o  = en_q;
endmodule

// File: rtl/ovh_byte_path.sv
`timescale 1ns/1ps
module ovh_byte_path
   import ovh_insert_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1,
   localparam int PH_W     = cnt_width(BYTE_W),
   localparam int HALF     = BYTE_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  port_mode_e        act_mode,
   input  logic [PH_W-1:0]   ph_idx,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              ser_o,
   output logic              dclk_o
);
   logic [BYTE_W-1:0] sh_q, sh_next;
   logic              ser_q, dclk_q;
   logic              is_active, load, first_bit, next_bit;

   assign is_active = (act_mode == MODE_BYTE);
   assign load      = is_active && (ph_idx == '0);

   generate
      if (MSB_FIRST) begin : g_msb
         assign first_bit = byte_i[BYTE_W-1];
         assign next_bit  = sh_q[BYTE_W-1];
         assign sh_next   = load ? {byte_i[BYTE_W-2:0], 1'b0}
                                 : {sh_q[BYTE_W-2:0], 1'b0};
      end else begin : g_lsb
         assign first_bit = byte_i[0];
         assign next_bit  = sh_q[0];
         assign sh_next   = load ? {1'b0, byte_i[BYTE_W-1:1]}
                                 : {1'b0, sh_q[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         ser_q  <= 1'b0;
         dclk_q <= 1'b0;
      end else begin
         dclk_q <= is_active && (ph_idx < PH_W'(HALF));
         ser_q  <= is_active && (load ? first_bit : next_bit);
         if (is_active)
            sh_q <= sh_next;
      end
   end

   assign ser_o  = ser_q;
   assign dclk_o = dclk_q;
endmodule

// File: rtl/ovh_insert_port.sv
`timescale 1ns/1ps
module ovh_insert_port
   import ovh_insert_pkg::*;
#(
   parameter int PAYLOAD_BITS = 84,
   parameter int BLOCKS       = 56,
   parameter int BYTE_W       = 8,
   parameter bit MSB_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_req_i,
   input  logic [BLOCKS-1:0] cfg_ovh_i,
   input  logic              pay_bit_i,
   input  logic              ins_req_i,
   input  logic              ovh_dat_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              mark_o,
   output logic              ovh_en_o,
   output logic              ser_o
);
   localparam int FRAME_LEN = BLOCKS * (PAYLOAD_BITS + 1);
   localparam int BLK_W     = cnt_width(BLOCKS);
   localparam int PH_W      = cnt_width(BYTE_W);

   generate
      if (PAYLOAD_BITS < 1) begin : g_bad_payload
         $error("PAYLOAD_BITS must be at least 1");
      end
      if (BLOCKS < 1) begin : g_bad_blocks
         $error("BLOCKS must be at least 1");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
      if ((FRAME_LEN % BYTE_W) != 0) begin : g_bad_align
         $error("frame length must be a whole number of bytes");
      end
   endgenerate

   logic             oh_now, oh_next, first_now;
   logic [BLK_W-1:0] blk_idx;
   logic [PH_W-1:0]  ph_idx;
   port_mode_e       act_mode, nxt_mode;
   logic             ovh_ser, ovh_frm, ovh_en;
   logic             byt_ser, byt_dclk;

   ovh_frame_ctr #(
      .PAYLOAD_BITS(PAYLOAD_BITS),
      .BLOCKS      (BLOCKS),
      .BYTE_W      (BYTE_W)
   ) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .mode_req_i(mode_req_i),
      .oh_now    (oh_now),
      .oh_next   (oh_next),
      .first_now (first_now),
      .blk_idx   (blk_idx),
      .ph_idx    (ph_idx),
      .act_mode  (act_mode),
      .nxt_mode  (nxt_mode)
   );

   ovh_bit_path #(
      .BLOCKS(BLOCKS)
   ) u_ovh (
      .clk      (clk),
      .rst      (rst),
      .act_mode (act_mode),
      .nxt_mode (nxt_mode),
      .oh_now   (oh_now),
      .oh_next  (oh_next),
      .first_now(first_now),
      .blk_idx  (blk_idx),
      .cfg_ovh_i(cfg_ovh_i),
      .pay_bit_i(pay_bit_i),
      .ins_req_i(ins_req_i),
      .ovh_dat_i(ovh_dat_i),
      .ser_o    (ovh_ser),
      .frm_o    (ovh_frm),
      .en_o     (ovh_en)
   );

   ovh_byte_path #(
      .BYTE_W   (BYTE_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_byte (
      .clk     (clk),
      .rst     (rst),
      .act_mode(act_mode),
      .ph_idx  (ph_idx),
      .byte_i  (byte_i),
      .ser_o   (byt_ser),
      .dclk_o  (byt_dclk)
   );

   // Each path holds its registers at zero while the other mode is active.
   assign ser_o    = ovh_ser | byt_ser;
   assign mark_o   = ovh_frm | byt_dclk;
   assign ovh_en_o = ovh_en;
endmodule

// File: rtl/ovh_insert_chk.sv
`timescale 1ns/1ps
module ovh_insert_chk (
   input logic clk,
   input logic rst,
   input logic act_byte,
   input logic oh_now,
   input logic first_now,
   input logic ins_req_i,
   input logic ovh_dat_i,
   input logic mark_o,
   input logic ovh_en_o,
   input logic ser_o
);
   assert_mark_single_R2: assert property (@(posedge clk) disable iff (rst)
      (mark_o && !act_byte) |=> !mark_o);

   assert_en_aligned_R3: assert property (@(posedge clk) disable iff (rst)
      ovh_en_o |-> oh_now);

   assert_en_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      ovh_en_o |=> !ovh_en_o);

   assert_insert_value_R4: assert property (@(posedge clk) disable iff (rst)
      (ovh_en_o && ins_req_i) |=> (ser_o == $past(ovh_dat_i)));

   assert_byte_no_enable_R7: assert property (@(posedge clk) disable iff (rst)
      act_byte |-> !ovh_en_o);

   assert_mode_boundary_R11: assert property (@(posedge clk) disable iff (rst)
      !$stable(act_byte) |-> first_now);
endmodule

bind ovh_insert_port ovh_insert_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .act_byte (act_mode),
   .oh_now   (oh_now),
   .first_now(first_now),
   .ins_req_i(ins_req_i),
   .ovh_dat_i(ovh_dat_i),
   .mark_o   (mark_o),
   .ovh_en_o (ovh_en_o),
   .ser_o    (ser_o)
);

// File: tb/ovh_insert_port_tb.sv
`timescale 1ns/1ps
module ovh_insert_port_tb;
   localparam int P  = 7;
   localparam int B  = 4;
   localparam int BW = 8;
   localparam int F  = B * (P + 1);
   localparam int NCYC = 1400;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mode_req = 1'b0;
   logic [B-1:0]  cfg = 4'b1011;
   logic          pay = 1'b0, ins = 1'b0, dat = 1'b0;
   logic [BW-1:0] byt = '0;
   logic          mark, en, ser;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   ovh_insert_port #(.PAYLOAD_BITS(P), .BLOCKS(B), .BYTE_W(BW)) u_dut (
      .clk(clk), .rst(rst), .mode_req_i(mode_req), .cfg_ovh_i(cfg),
      .pay_bit_i(pay), .ins_req_i(ins), .ovh_dat_i(dat), .byte_i(byt),
      .mark_o(mark), .ovh_en_o(en), .ser_o(ser)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   int         pos = 0;
   logic       mode_cur = 1'b0;
   logic       en_cur = 1'b0;
   logic [7:0] lat = '0;
   bit         fresh = 1'b0;

   initial begin
      logic e_mark, e_en, e_ser;
      string t_mark, t_en, t_ser;
      for (int c = 0; c < NCYC; c++) begin
         rst = (c < 3) || (c >= 700 && c < 702) || (c >= 1000 && c < 1002);
         mode_req = (((c + 13) / 80) % 2 == 1) ^ ((c % 32) >= 5 && (c % 32) < 9);
         if (c >= 700 && c < 702) mode_req = 1'b1;
         if (c >= 1000 && c < 1002) mode_req = 1'b0;
         pay = 1'($urandom);
         ins = 1'($urandom);
         dat = 1'($urandom);
         byt = 8'($urandom);
         if (c == 3 || c == 1002) begin
            ins = 1'b1;        // insert request with no preceding enable
            dat = ~cfg[0];
         end
         if (rst) begin
            e_mark = 0; e_en = 0; e_ser = 0;
            t_mark = "R1"; t_en = "R1"; t_ser = "R1";
            pos = 0; mode_cur = mode_req; en_cur = 0; lat = '0; fresh = 0;
         end else begin
            int bi, blk, ph;
            bi = pos % (P + 1); blk = pos / (P + 1); ph = pos % BW;
            if (!mode_cur) begin
               e_mark = (pos == 0);
               t_mark = "R2"; t_en = "R3";
               if (bi == 0) begin
                  if (en_cur && ins) begin e_ser = dat; t_ser = "R4"; end
                  else begin e_ser = cfg[blk]; t_ser = "R5"; end
               end else begin
                  e_ser = pay; t_ser = "R6";
               end
            end else begin
               if (ph == 0) lat = byt;
               e_ser = lat[7 - ph];
               e_mark = (ph < BW / 2);
               t_mark = "R7"; t_en = "R7"; t_ser = "R8 R9 R10";
            end
            if (pos == F - 1) begin
               fresh = (mode_req != mode_cur);
               mode_cur = mode_req;
            end
            pos = (pos + 1) % F;
            en_cur = !mode_cur && (pos % (P + 1) == 0);
            e_en = en_cur;
            if (fresh) begin
               t_mark = {"R11 ", t_mark}; t_en = {"R11 ", t_en}; t_ser = {"R11 ", t_ser};
            end
         end
         @(negedge clk);
         chk(t_mark, mark, e_mark);
         chk(t_en, en, e_en);
         chk(t_ser, ser, e_ser);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule